// File: doc/BRIEF.md
# LIN Break Detector and Generator

This unit sits beside a UART-style receiver and transmitter and handles the long dominant (low) break symbol that opens a LIN frame. Three mode inputs (a transmit-break enable, a receive-break enable and a character-length bit) are decoded into a receive detection threshold and a transmit break length. With neither enable set, the unit stays out of the way and the serial line behaves as a plain UART.

The receive side passes the serial input through a two-flop synchronizer and then samples it once per bit, in the middle of the bit. It counts consecutive low samples. It raises a single-cycle break flag only when the count reaches the threshold, which is 11 or 12 bit times. A 0x00 data character from a node whose clock is up to 15% slow can look as long as 10.35 bit times. Such a character never reaches the threshold. A true break can look as short as 11.05 bit times, and it still does. On the transmit side, a request taken while idle drives the line low for 13 or 14 bit times, adds one high delimiter bit, and then pulses a done strobe.

Bit timing comes from a free-running two-stage divider. A prescaler divides by 1, 3, 4 or 13, and a power-of-two stage divides by 1 to 128. Each bit spans `OVS` ticks (default 4). Receive states are R_IDLE, R_COUNT and R_HELD. R_IDLE moves to R_COUNT on a low synchronized line when detection is on. R_COUNT returns to R_IDLE on a high mid-bit sample, or moves to R_HELD, raising the flag, when the count meets the threshold. R_HELD returns to R_IDLE once the line goes high. Transmit states are T_IDLE, T_BREAK and T_DELIM. T_IDLE moves to T_BREAK on an accepted request. T_BREAK moves to T_DELIM after the chosen number of bits. T_DELIM returns to T_IDLE after one bit, pulsing done.

Top module: `lin_break_unit`

## Requirements
- R1: With `tx_brk_en` and `rx_brk_en` both 0, `long_char` has no effect. No flag ever pulses, a `brk_req` is not taken, `tx_busy` stays 0 and `txd` stays 1.
- R2: With only receive detection on, the flag pulses at the mid-bit sample of the 11th consecutive low bit when `long_char`=0, and of the 12th when `long_char`=1. With a tick every clock, the first sample comes 2+OVS/2 cycles after the line falls and later samples follow every OVS cycles, so the flag appears 4·thr to 4·thr+2 cycles after the fall.
- R3: With only transmit on, an accepted request holds `txd` low for 13 bit periods (`long_char`=0) or 14 (`long_char`=1). `txd` is then high for exactly one bit period, after which `brk_done` pulses for one cycle.
- R4: With both enables on, detection and generation pair as 11 and 13 when `long_char`=0, and as 12 and 14 when it is 1.
- R5: At threshold 11, a low lasting 10.5 bit times gives no flag and a low lasting 11.5 bit times gives one.
- R6: One low period raises at most one flag, however long it lasts. A high mid-bit sample clears the count, and a new fall starts counting again from zero.
- R7: `brk_req` is taken only in T_IDLE. A request during a break or delimiter is dropped and produces no second break.
- R8: The mode inputs are captured only while the matching side is idle. A change of `long_char` during a break alters neither the break length nor the detection threshold.
- R9: A bit lasts OVS ticks. A tick comes every P·D clocks, where `pre_sel` 0,1,2,3 selects P = 1,3,4,13 and `div_sel` n selects D = 2^n.
- R10: During and after reset, `txd`=1 and `brk_flag`, `brk_done` and `tx_busy` are 0. The captured receive enable is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_brk_en | input | 1 | Enables break generation |
| rx_brk_en | input | 1 | Enables break detection |
| long_char | input | 1 | Character-length bit; selects the longer threshold and length |
| pre_sel | input | 2 | Prescaler select (1, 3, 4, 13) |
| div_sel | input | DIV_SEL_W | Power-of-two divider select |
| rxd | input | 1 | Serial receive line, asynchronous |
| brk_req | input | 1 | Request to send a break |
| txd | output | 1 | Serial transmit line, idles high |
| brk_flag | output | 1 | One-cycle break detected pulse |
| brk_done | output | 1 | One-cycle pulse after the delimiter |
| tx_busy | output | 1 | High from break start until the delimiter ends |

## Verification
The assertions assume that `brk_req` and the mode inputs are synchronous to `clk` and free of unknown values once reset is released. They also assume the divider selects stay steady across a tick, unless they are deliberately changed. The stimulus drives every input on the falling clock edge. It changes the divider selects only while both sides are idle, and then waits for the divider to settle before timing a break. The single mid-break change of `long_char` is made on purpose to exercise the capture rule.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
    localparam int CNT_W       = 5;
    localparam int RX_THR_BASE = 11;
    localparam int TX_LEN_BASE = 13;

    typedef struct packed {
        logic             rx_on;
        logic [CNT_W-1:0] rx_thr;
        logic             tx_on;
        logic [CNT_W-1:0] tx_len;
    } brk_mode_t;

    typedef enum logic [1:0] {R_IDLE, R_COUNT, R_HELD} rx_state_t;
    typedef enum logic [1:0] {T_IDLE, T_BREAK, T_DELIM} tx_state_t;

    // Enables off: fields forced to zero so the length bit cannot matter.
    function automatic brk_mode_t decode_mode(input logic tx_en, input logic rx_en,
                                              input logic long_chr);
        brk_mode_t m;
        m.rx_on  = rx_en;
        m.tx_on  = tx_en;
        m.rx_thr = rx_en ? CNT_W'(RX_THR_BASE) + CNT_W'(long_chr) : '0;
        m.tx_len = tx_en ? CNT_W'(TX_LEN_BASE) + CNT_W'(long_chr) : '0;
        return m;
    endfunction

    function automatic logic [3:0] pre_divisor(input logic [1:0] sel);
        logic [3:0] d;
        case (sel)
            2'd0:    d = 4'd1;
            2'd1:    d = 4'd3;
            2'd2:    d = 4'd4;
            default: d = 4'd13;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/lin_baud_tick.sv
module lin_baud_tick
    import lin_brk_pkg::*;
#(
    parameter int DIV_SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           pre_sel,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);
    localparam int DIV_W = (1 << DIV_SEL_W) - 1;

    logic [3:0]       pre_cnt, pre_lim;
    logic [DIV_W-1:0] div_cnt, div_lim;
    logic [DIV_W:0]   div_pow;
    logic             pre_hit, div_hit;

    always_comb begin
        pre_lim = pre_divisor(pre_sel) - 4'd1;
        div_pow = {{DIV_W{1'b0}}, 1'b1} << div_sel;
        div_lim = DIV_W'(div_pow - 1'b1);
        pre_hit = (pre_cnt >= pre_lim);
        div_hit = (div_cnt >= div_lim);
        tick    = pre_hit && div_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else begin
            pre_cnt <= pre_hit ? '0 : pre_cnt + 4'd1;
            if (pre_hit) div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
        end
    end

    // Unless both stages divide by one, two ticks are never adjacent.
    assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (pre_lim != 4'd0 || div_lim != '0)) |=>
        (!tick || !$stable(pre_sel) || !$stable(div_sel)));
endmodule

// File: rtl/lin_rx_break.sv
module lin_rx_break
    import lin_brk_pkg::*;
#(
    parameter int OVS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd,
    input  logic             mode_on,
    input  logic [CNT_W-1:0] mode_thr,
    output logic             brk_flag
);
    localparam int PH_W = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int HALF = OVS / 2;

    rx_state_t        state, nxt;
    logic             sync1, rx_s;
    logic [PH_W-1:0]  ph;
    logic [CNT_W-1:0] cnt, thr_q;
    logic             on_q, sample, reach;

    always_comb begin
        sample = tick && (ph == '0);
        reach  = sample && !rx_s && (CNT_W'(cnt + 1'b1) == thr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            rx_s  <= 1'b1;
        end else begin
            sync1 <= rxd;
            rx_s  <= sync1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= R_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            R_IDLE:  if (on_q && !rx_s) nxt = R_COUNT;
            R_COUNT: if (sample && rx_s) nxt = R_IDLE;
                     else if (reach)     nxt = R_HELD;
            R_HELD:  if (rx_s) nxt = R_IDLE;
            default: nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q     <= 1'b0;
            thr_q    <= '0;
            cnt      <= '0;
            ph       <= '0;
            brk_flag <= 1'b0;
        end else begin
            brk_flag <= 1'b0;
            unique case (state)
                R_IDLE: begin
                    on_q  <= mode_on;
                    thr_q <= mode_thr;
                    cnt   <= '0;
                    ph    <= PH_W'(HALF - 1);
                end
                R_COUNT: begin
                    if (tick) ph <= (ph == '0) ? PH_W'(OVS - 1) : ph - 1'b1;
                    if (sample && !rx_s) cnt <= cnt + 1'b1;
                    if (reach) brk_flag <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_single_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_flag |=> !brk_flag);
    assert_flag_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        brk_flag |-> !$past(rx_s));
    assert_flag_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        brk_flag |-> on_q);
    assert_thr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != R_IDLE && $past(state) != R_IDLE) |-> $stable(thr_q));
endmodule

// File: rtl/lin_tx_break.sv
module lin_tx_break
    import lin_brk_pkg::*;
#(
    parameter int OVS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             brk_req,
    input  logic             mode_on,
    input  logic [CNT_W-1:0] mode_len,
    output logic             txd,
    output logic             busy,
    output logic             done
);
    localparam int PH_W = (OVS > 2) ? $clog2(OVS) : 1;

    tx_state_t        state, nxt;
    logic [PH_W-1:0]  ph;
    logic [CNT_W-1:0] bits, len_q;
    logic             bit_end, accept;

    always_comb begin
        bit_end = tick && (ph == '0);
        accept  = (state == T_IDLE) && mode_on && brk_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= T_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            T_IDLE:  if (accept) nxt = T_BREAK;
            T_BREAK: if (bit_end && CNT_W'(bits + 1'b1) == len_q) nxt = T_DELIM;
            T_DELIM: if (bit_end) nxt = T_IDLE;
            default: nxt = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph    <= '0;
            bits  <= '0;
            len_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                T_IDLE: begin
                    ph    <= PH_W'(OVS - 1);
                    bits  <= '0;
                    len_q <= mode_len;
                end
                T_BREAK: begin
                    if (tick)    ph   <= (ph == '0) ? PH_W'(OVS - 1) : ph - 1'b1;
                    if (bit_end) bits <= bits + 1'b1;
                end
                T_DELIM: begin
                    if (tick)    ph   <= (ph == '0) ? PH_W'(OVS - 1) : ph - 1'b1;
                    if (bit_end) done <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        txd  = (state != T_BREAK);
        busy = (state != T_IDLE);
    end

    assert_req_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> $past(brk_req && !busy));
    assert_done_after_delim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (txd && $past(txd)));
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_len_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(len_q));
endmodule

// File: rtl/lin_break_unit.sv
module lin_break_unit
    import lin_brk_pkg::*;
#(
    parameter int OVS       = 4,
    parameter int DIV_SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_brk_en,
    input  logic                 rx_brk_en,
    input  logic                 long_char,
    input  logic [1:0]           pre_sel,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 rxd,
    input  logic                 brk_req,
    output logic                 txd,
    output logic                 brk_flag,
    output logic                 brk_done,
    output logic                 tx_busy
);
    brk_mode_t mode;
    logic      tick;

    assign mode = decode_mode(tx_brk_en, rx_brk_en, long_char);

    lin_baud_tick #(.DIV_SEL_W(DIV_SEL_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .div_sel(div_sel), .tick(tick));

    lin_rx_break #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .mode_on(mode.rx_on), .mode_thr(mode.rx_thr), .brk_flag(brk_flag));

    lin_tx_break #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .brk_req(brk_req),
        .mode_on(mode.tx_on), .mode_len(mode.tx_len),
        .txd(txd), .busy(tx_busy), .done(brk_done));

    assert_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);
endmodule

// File: tb/lin_break_unit_bench.sv
module lin_break_unit_bench;
    localparam int OVS = 4;
    localparam int K_FLAG = 0, K_LOW = 1, K_DONE = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_en = 1'b0, rx_en = 1'b0, lc = 1'b0, rxd = 1'b1, req = 1'b0;
    logic [1:0] ps = 2'd0;
    logic [2:0] ds = 3'd0;
    logic txd, flag, done, busy;

    always #5 clk = ~clk;

    lin_break_unit u_lin_break_unit (
        .clk(clk), .rst_n(rst_n), .tx_brk_en(tx_en), .rx_brk_en(rx_en),
        .long_char(lc), .pre_sel(ps), .div_sel(ds), .rxd(rxd), .brk_req(req),
        .txd(txd), .brk_flag(flag), .brk_done(done), .tx_busy(busy));

    typedef struct {int kind; int lo; int hi; string rq;} exp_t;
    exp_t  sb[$];
    int    checks = 0, fails = 0, cyc = 0;
    int    fall_cyc = 0, t_low = 0, t_high = 0;
    logic  txd_prev = 1'b1;
    string cur_req = "R10";

    always @(posedge clk) cyc = cyc + 1;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic push_exp(input int k, input int lo, input int hi);
        exp_t e;
        e.kind = k; e.lo = lo; e.hi = hi; e.rq = cur_req;
        sb.push_back(e);
    endtask

    task automatic score(input int k, input int v);
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
            fails++;
            $display("FAIL %s unexpected event kind=%0d value=%0d expected no event", cur_req, k, v);
        end else begin
            e = sb.pop_front();
            if (e.kind != k || v < e.lo || v > e.hi) begin
                fails++;
                $display("FAIL %s actual kind=%0d value=%0d expected kind=%0d value %0d..%0d",
                         e.rq, k, v, e.kind, e.lo, e.hi);
            end
        end
    endtask

    // Monitor: turns pulses and line edges into scored events.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!txd && txd_prev) t_low = cyc;
            if (txd && !txd_prev) begin
                score(K_LOW, cyc - t_low);
                t_high = cyc;
            end
            if (done) score(K_DONE, cyc - t_high);
            if (flag) score(K_FLAG, cyc - fall_cyc);
            txd_prev = txd;
        end
    end

    task automatic drain();
        exp_t e;
        repeat (30) @(negedge clk);
        while (sb.size() > 0) begin
            e = sb.pop_front();
            checks++; fails++;
            $display("FAIL %s missing event kind=%0d actual=none expected value %0d..%0d",
                     e.rq, e.kind, e.lo, e.hi);
        end
    endtask

    task automatic rx_low(input int n, input bit exp, input int thr);
        @(negedge clk);
        rxd = 1'b0;
        fall_cyc = cyc;
        if (exp) push_exp(K_FLAG, OVS * thr, OVS * thr + 2);
        repeat (n) @(negedge clk);
        rxd = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic tx_brk(input int len, input int p);
        push_exp(K_LOW, (len * OVS - 1) * p + 1, len * OVS * p);
        push_exp(K_DONE, OVS * p, OVS * p);
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(txd == 1'b1, "R10 txd", txd, 1);
        chk(flag == 1'b0 && done == 1'b0 && busy == 1'b0, "R10 outputs", {flag, done, busy}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: plain mode, length bit both ways
        cur_req = "R1";
        for (int v = 0; v < 2; v++) begin
            lc = v[0];
            rx_low(60, 0, 0);
            @(negedge clk); req = 1'b1;
            @(negedge clk); req = 1'b0;
            repeat (6) @(negedge clk);
            chk(busy == 1'b0 && txd == 1'b1, "R1 tx ignored", {busy, txd}, 1);
            drain();
        end

        // R2/R5: receive-only thresholds
        rx_en = 1'b1; lc = 1'b0; repeat (4) @(negedge clk);
        cur_req = "R5"; rx_low(42, 0, 0); drain();
        cur_req = "R5"; rx_low(46, 1, 11); drain();
        lc = 1'b1; repeat (4) @(negedge clk);
        cur_req = "R2"; rx_low(46, 0, 0); drain();
        cur_req = "R2"; rx_low(50, 1, 12); drain();

        // R6: long low gives one flag; interrupted low restarts
        lc = 1'b0; repeat (4) @(negedge clk);
        cur_req = "R6"; rx_low(120, 1, 11); drain();
        cur_req = "R6"; rx_low(24, 0, 0); rx_low(46, 1, 11); drain();

        // R3: transmit-only lengths
        rx_en = 1'b0; tx_en = 1'b1; lc = 1'b0; repeat (4) @(negedge clk);
        cur_req = "R3"; tx_brk(13, 1); drain();
        lc = 1'b1; repeat (2) @(negedge clk);
        cur_req = "R3"; tx_brk(14, 1); drain();

        // R4: both enabled, paired
        rx_en = 1'b1; lc = 1'b0; repeat (4) @(negedge clk);
        cur_req = "R4"; tx_brk(13, 1); rx_low(46, 1, 11); rx_low(42, 0, 0); drain();
        lc = 1'b1; repeat (4) @(negedge clk);
        cur_req = "R4"; tx_brk(14, 1); rx_low(50, 1, 12); rx_low(46, 0, 0); drain();

        // R7: second request during break is dropped
        lc = 1'b0; repeat (4) @(negedge clk);
        cur_req = "R7";
        push_exp(K_LOW, 52, 52); push_exp(K_DONE, 4, 4);
        @(negedge clk); req = 1'b1; @(negedge clk); req = 1'b0;
        repeat (20) @(negedge clk); req = 1'b1; @(negedge clk); req = 1'b0;
        repeat (34) @(negedge clk); req = 1'b1; @(negedge clk); req = 1'b0;
        while (busy) @(negedge clk);
        drain();
        chk(busy == 1'b0 && txd == 1'b1, "R7 idle after", {busy, txd}, 1);

        // R8: length bit flipped mid-break / mid-count
        cur_req = "R8";
        push_exp(K_LOW, 52, 52); push_exp(K_DONE, 4, 4);
        @(negedge clk); req = 1'b1; @(negedge clk); req = 1'b0;
        repeat (10) @(negedge clk); lc = 1'b1;
        while (busy) @(negedge clk);
        drain();
        lc = 1'b0; repeat (4) @(negedge clk);
        @(negedge clk); rxd = 1'b0; fall_cyc = cyc;
        push_exp(K_FLAG, 44, 46);
        repeat (20) @(negedge clk); lc = 1'b1;
        repeat (40) @(negedge clk); rxd = 1'b1;
        drain();
        lc = 1'b0;

        // R9: divider settings
        rx_en = 1'b0; lc = 1'b0;
        cur_req = "R9"; ps = 2'd1; ds = 3'd2; repeat (200) @(negedge clk);
        tx_brk(13, 12); drain();
        lc = 1'b1; ps = 2'd3; ds = 3'd0; repeat (200) @(negedge clk);
        tx_brk(14, 13); drain();
        lc = 1'b0; ps = 2'd2; ds = 3'd3; repeat (200) @(negedge clk);
        tx_brk(13, 32); drain();

        summary();
        $finish;
    end
endmodule